// File: doc/BRIEF.md
# Hypervisor Debug Trap Controller

This block keeps the hypervisor's debug and monitor configuration word and decides, access by access, whether a lower-privilege request must be sent to the hypervisor. Software writes the word through a single-cycle write port, and the stored value is always visible on a read-back bus. Each request carries a privilege level (0, 1 or 2), a security state, a register class and a read/write direction. The block answers combinationally with a trap-to-hypervisor flag that is valid in the same cycle as the request strobe.

Some trap bits have an effective value that differs from the stored one. A general-trap override input forces debug routing on. Debug routing, whether stored or forced, in turn forces the OS-debug trap and the general debug trap on. These forced values steer the decision but never appear on read-back. A second output tells the exception logic that software debug exceptions from non-secure levels 0 and 1 go to level 2. A third output exposes the hypervisor counter-enable bit to the counter logic.

The block does not decode register addresses into classes. It does not contain the counters or the debug logic.

Top module: `hyp_dbg_trap_ctrl`

## Requirements
- R1: After reset is released, stored bits 10, 9, 8, 6 and 5 read back as 0. Bit 7 has no defined reset value.
- R2: A write with `cfg_wr_en` high stores bits 10 down to 5 of `cfg_wr_data` at the next clock edge. `cfg_rd_data` then shows them. All other bits always read 0.
- R3: Bit 10 is the OS-debug trap. When its effective value is 1, a valid non-secure access from level 0 or 1 to class 1 (OS-lock, OS-lock-status, OS-double-lock, power-control) asserts `trap_to_hyp`.
- R4: Bit 9 is the general debug trap. When its effective value is 1, a valid non-secure access from level 0 or 1 to class 2 (general debug) traps. Class 3 (debug ROM) is never trapped by this bit. Class 1 is not trapped by bit 9 alone.
- R5: When `gen_trap_ovr` is 1, bit 8 (debug routing) behaves as 1. When debug routing is effectively 1, bits 10 and 9 behave as 1.
- R6: Forced effective values never change `cfg_rd_data`. The stored word changes only through a write.
- R7: `dbg_exc_to_hyp` is 1 exactly when debug routing is effectively 1 and the request context is non-secure at level 0 or 1. It does not depend on `req_valid`.
- R8: Bit 6 traps valid non-secure level 0/1 accesses to class 4 (allocated monitor registers) and class 5 (monitor control). Class 6 (unallocated monitor encodings) never traps.
- R9: Bit 5 traps valid non-secure level 0/1 accesses to class 5 only.
- R10: Secure accesses, accesses from level 2 or 3, accesses of class 0 or 7, and cycles with `req_valid` low never assert `trap_to_hyp`.
- R11: `ctr_en` equals stored bit 7.
- R12: `req_write` has no effect on `trap_to_hyp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low warm reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | REG_W | Write data |
| cfg_rd_data | output | REG_W | Stored configuration word |
| req_valid | input | 1 | Access request strobe |
| req_el | input | 2 | Privilege level of the request context |
| req_nonsecure | input | 1 | 1 = non-secure context |
| req_class | input | 3 | Register class code (0 none, 1 OS debug, 2 debug, 3 debug ROM, 4 monitor, 5 monitor control, 6 unallocated monitor, 7 none) |
| req_write | input | 1 | 1 = write access, 0 = read access |
| gen_trap_ovr | input | 1 | General-trap override |
| trap_to_hyp | output | 1 | Access must trap to level 2 |
| dbg_exc_to_hyp | output | 1 | Software debug exceptions go to level 2 |
| ctr_en | output | 1 | Hypervisor counter enable (stored bit 7) |

## Verification
The decision is swept over every class, level, security state, direction and strobe value. The sweep is repeated under each single trap bit, all bits set, no bits set, and a word with only unimplemented bits, each with and without the override. Single-bit words show which bit traps which class. The override and routing cases separate stored from effective values, since read-back must stay unchanged while traps appear. A paired read/write pass with an otherwise frozen request shows that direction plays no part in the answer.

// File: rtl/hdt_pkg.sv
package hdt_pkg;
    localparam int unsigned CLS_W   = 3;
    localparam int unsigned POS_PCR = 5;
    localparam int unsigned POS_PMT = 6;
    localparam int unsigned POS_CEN = 7;
    localparam int unsigned POS_RTE = 8;
    localparam int unsigned POS_GDT = 9;
    localparam int unsigned POS_OST = 10;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE    = 3'd0,
        CLS_OSDBG   = 3'd1,
        CLS_DBG     = 3'd2,
        CLS_DBGROM  = 3'd3,
        CLS_MON     = 3'd4,
        CLS_MONCTL  = 3'd5,
        CLS_MONUNAL = 3'd6,
        CLS_SPARE   = 3'd7
    } acc_class_e;

    typedef struct packed {
        logic ost;
        logic gdt;
        logic rte;
        logic pmt;
        logic pcr;
    } trap_bits_t;
endpackage

// File: rtl/hdt_cfg_reg.sv
module hdt_cfg_reg #(
    parameter int unsigned         REG_W    = 32,
    parameter logic [REG_W-1:0]    IMPL_MSK = '0,
    parameter logic [REG_W-1:0]    RST_MSK  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_q
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^(wr_data & ~IMPL_MSK);

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (RST_MSK[b]) begin : g_rst
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     bit_q <= 1'b0;
                else if (wr_en) bit_q <= wr_data[b];
            end
            assign cfg_q[b] = bit_q;
        end else if (IMPL_MSK[b]) begin : g_norst
            logic bit_q;
            always_ff @(posedge clk) begin
                if (wr_en) bit_q <= wr_data[b];
            end
            assign cfg_q[b] = bit_q;
        end else begin : g_none
            assign cfg_q[b] = 1'b0;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((cfg_q & RST_MSK) == '0));

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && rst_n) |-> (cfg_q == ($past(wr_data) & IMPL_MSK)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(cfg_q));
endmodule

// File: rtl/hdt_eff_ctrl.sv
module hdt_eff_ctrl
    import hdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trap_bits_t stored,
    input  logic       ovr,
    output trap_bits_t eff
);
    always_comb begin
        eff     = stored;
        eff.rte = stored.rte | ovr;
        eff.ost = stored.ost | eff.rte;
        eff.gdt = stored.gdt | eff.rte;
    end

    assert_force_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> (eff.rte && eff.ost && eff.gdt));

    assert_force_rte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stored.rte |-> (eff.ost && eff.gdt));
endmodule

// File: rtl/hdt_trap_decide.sv
module hdt_trap_decide
    import hdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  trap_bits_t       eff,
    input  logic             req_valid,
    input  logic [1:0]       req_el,
    input  logic             req_nonsecure,
    input  logic [CLS_W-1:0] req_class,
    output logic             trap,
    output logic             route
);
    logic lower_ns;
    logic hit;

    assign lower_ns = req_nonsecure && !req_el[1];

    always_comb begin
        unique case (acc_class_e'(req_class))
            CLS_OSDBG:  hit = eff.ost;
            CLS_DBG:    hit = eff.gdt;
            CLS_MON:    hit = eff.pmt;
            CLS_MONCTL: hit = eff.pmt | eff.pcr;
            default:    hit = 1'b0;
        endcase
    end

    assign trap  = req_valid && lower_ns && hit;
    assign route = eff.rte && lower_ns;

    assert_no_trap_secure_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_nonsecure || req_el[1] || !req_valid) |-> !trap);

    assert_unalloc_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_class == CLS_MONUNAL || req_class == CLS_DBGROM) |-> !trap);

    assert_osdbg_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eff.ost && req_valid && req_nonsecure && !req_el[1] && req_class == CLS_OSDBG) |-> trap);

    assert_route_lower_R7: assert property (@(posedge clk) disable iff (!rst_n)
        route |-> (req_nonsecure && !req_el[1]));
endmodule

// File: rtl/hyp_dbg_trap_ctrl.sv
module hyp_dbg_trap_ctrl
    import hdt_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wr_data,
    output logic [REG_W-1:0] cfg_rd_data,
    input  logic             req_valid,
    input  logic [1:0]       req_el,
    input  logic             req_nonsecure,
    input  logic [CLS_W-1:0] req_class,
    input  logic             req_write,
    input  logic             gen_trap_ovr,
    output logic             trap_to_hyp,
    output logic             dbg_exc_to_hyp,
    output logic             ctr_en
);
    localparam logic [REG_W-1:0] ONE      = REG_W'(1);
    localparam logic [REG_W-1:0] RST_MSK  = (ONE << POS_OST) | (ONE << POS_GDT) |
                                            (ONE << POS_RTE) | (ONE << POS_PMT) |
                                            (ONE << POS_PCR);
    localparam logic [REG_W-1:0] IMPL_MSK = RST_MSK | (ONE << POS_CEN);

    logic [REG_W-1:0] cfg_q;
    trap_bits_t       stored;
    trap_bits_t       eff;

    hdt_cfg_reg #(
        .REG_W    (REG_W),
        .IMPL_MSK (IMPL_MSK),
        .RST_MSK  (RST_MSK)
    ) i_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_q   (cfg_q)
    );

    assign stored.ost = cfg_q[POS_OST];
    assign stored.gdt = cfg_q[POS_GDT];
    assign stored.rte = cfg_q[POS_RTE];
    assign stored.pmt = cfg_q[POS_PMT];
    assign stored.pcr = cfg_q[POS_PCR];

    hdt_eff_ctrl i_eff (
        .clk    (clk),
        .rst_n  (rst_n),
        .stored (stored),
        .ovr    (gen_trap_ovr),
        .eff    (eff)
    );

    hdt_trap_decide i_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .eff           (eff),
        .req_valid     (req_valid),
        .req_el        (req_el),
        .req_nonsecure (req_nonsecure),
        .req_class     (req_class),
        .trap          (trap_to_hyp),
        .route         (dbg_exc_to_hyp)
    );

    assign cfg_rd_data = cfg_q;
    assign ctr_en      = cfg_q[POS_CEN];

    assert_dir_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(req_valid) && $stable(req_el) && $stable(req_nonsecure) &&
         $stable(req_class) && $stable(gen_trap_ovr) && $stable(cfg_q) &&
         (req_write != $past(req_write))) |-> $stable(trap_to_hyp));

    assert_ctr_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr_en && rst_n) |-> (ctr_en == $past(cfg_wr_data[POS_CEN])));

    assert_ovr_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_trap_ovr && req_nonsecure && !req_el[1]) |-> dbg_exc_to_hyp);
endmodule

// File: tb/test_hyp_dbg_trap_ctrl.sv
module test_hyp_dbg_trap_ctrl;
    localparam int REG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [REG_W-1:0] cfg_wr_data = '0;
    logic [REG_W-1:0] cfg_rd_data;
    logic             req_valid = 1'b0;
    logic [1:0]       req_el = 2'd0;
    logic             req_nonsecure = 1'b0;
    logic [2:0]       req_class = 3'd0;
    logic             req_write = 1'b0;
    logic             gen_trap_ovr = 1'b0;
    logic             trap_to_hyp;
    logic             dbg_exc_to_hyp;
    logic             ctr_en;

    int    checks = 0;
    int    errs = 0;
    bit    done = 0;
    bit    running = 0;
    string phase = "";

    // behavioural model state
    int unsigned st = 0;
    bit          known7 = 0;

    always #5 clk = ~clk;

    hyp_dbg_trap_ctrl #(.REG_W(REG_W)) i_hyp_dbg_trap_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_wr_data    (cfg_wr_data),
        .cfg_rd_data    (cfg_rd_data),
        .req_valid      (req_valid),
        .req_el         (req_el),
        .req_nonsecure  (req_nonsecure),
        .req_class      (req_class),
        .req_write      (req_write),
        .gen_trap_ovr   (gen_trap_ovr),
        .trap_to_hyp    (trap_to_hyp),
        .dbg_exc_to_hyp (dbg_exc_to_hyp),
        .ctr_en         (ctr_en)
    );

    // model register: implemented bits 10..5; bits 10,9,8,6,5 clear on reset
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= st & 32'h80;
        else if (cfg_wr_en) begin
            st     <= cfg_wr_data & 32'h7E0;
            known7 <= 1'b1;
        end
    end

    function automatic bit sbit(int p);
        return st[p];
    endfunction

    function automatic bit exp_route();
        bit r;
        r = sbit(8) | gen_trap_ovr;
        return r && req_nonsecure && (req_el < 2);
    endfunction

    function automatic bit exp_trap();
        bit r, os_e, gd_e;
        if (!req_valid || !req_nonsecure || req_el >= 2) return 0;
        r    = sbit(8) | gen_trap_ovr;
        os_e = sbit(10) | r;
        gd_e = sbit(9) | r;
        case (req_class)
            3'd1: return os_e;
            3'd2: return gd_e;
            3'd4: return sbit(6);
            3'd5: return sbit(6) | sbit(5);
            default: return 0;
        endcase
    endfunction

    function automatic string trap_tag();
        if (phase != "") return phase;
        if (!req_valid || !req_nonsecure || req_el >= 2) return "R10";
        if (gen_trap_ovr || sbit(8)) return "R5";
        case (req_class)
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4, 3'd6: return "R8";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (running && rst_n) begin
            logic [31:0] m;
            m = known7 ? 32'hFFFF_FFFF : ~32'h80;
            check((phase == "R1") ? "R1" :
                  ((gen_trap_ovr || sbit(8)) ? "R6" : "R2"),
                  cfg_rd_data & m, st & m);
            check(trap_tag(), {31'd0, trap_to_hyp}, {31'd0, exp_trap()});
            check("R7", {31'd0, dbg_exc_to_hyp}, {31'd0, exp_route()});
            if (known7) check("R11", {31'd0, ctr_en}, {31'd0, sbit(7)});
        end
    end

    task automatic write_cfg(logic [31:0] v);
        @(posedge clk); #1;
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(posedge clk); #1;
        cfg_wr_en   = 1'b0;
        cfg_wr_data = ~v;
    endtask

    task automatic sweep();
        for (int c = 0; c < 8; c++)
            for (int e = 0; e < 4; e++)
                for (int n = 0; n < 2; n++)
                    for (int w = 0; w < 2; w++)
                        for (int v = 0; v < 2; v++) begin
                            @(posedge clk); #1;
                            req_class     = 3'(c);
                            req_el        = 2'(e);
                            req_nonsecure = n[0];
                            req_write     = w[0];
                            req_valid     = v[0];
                        end
    endtask

    initial begin
        logic [31:0] cfgs [10];
        cfgs = '{32'h0, 32'h400, 32'h200, 32'h100, 32'h40,
                 32'h20, 32'h80, 32'hFFFF_FFFF, 32'hFFFF_F81F, 32'h660};
        running = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, with an OS-class access that must not trap
        phase         = "R1";
        req_valid     = 1'b1;
        req_nonsecure = 1'b1;
        req_el        = 2'd1;
        req_class     = 3'd1;
        repeat (2) @(posedge clk);
        #1 phase = "";
        // R2..R11: sweeps per configuration word and override
        for (int k = 0; k < 10; k++)
            for (int o = 0; o < 2; o++) begin
                @(posedge clk); #1 gen_trap_ovr = o[0];
                write_cfg(cfgs[k]);
                sweep();
            end
        // R12: paired direction flip with everything else frozen
        gen_trap_ovr = 1'b0;
        write_cfg(32'h460);
        phase = "R12";
        for (int c = 0; c < 8; c++)
            for (int e = 0; e < 4; e++)
                for (int n = 0; n < 2; n++) begin
                    logic t0;
                    @(posedge clk); #1;
                    req_valid = 1'b1; req_class = 3'(c);
                    req_el = 2'(e); req_nonsecure = n[0]; req_write = 1'b0;
                    @(negedge clk); t0 = trap_to_hyp;
                    @(posedge clk); #1 req_write = 1'b1;
                    @(negedge clk);
                    check("R12", {31'd0, trap_to_hyp}, {31'd0, t0});
                end
        running = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule